// File: doc/BRIEF.md
# Circular Self-Test Ring Register

This block is a bank of N state flip-flops that can double as its own self-test engine. In normal operation every cell is a plain D flip-flop that loads its functional input on each clock. When test mode is enabled, the cells are joined in a closed ring. Each cell captures its functional input XORed with the current state of the cell before it, and the first cell takes the state of the last cell. The combinational logic fed by the register supplies the next stimulus, and the ring compacts the responses at the same time, so no separate pattern source or signature register is needed. The ring is a multiple-input signature register with characteristic polynomial x^n+1.

A synchronous master reset puts every cell into a known all-zero state before a test run, so that no unknown value can enter the signature. A cycle counter limits a run to a programmed number of capture clocks. The block then raises done and freezes the ring, and the frozen ring contents are the signature.

Top module: `cstp_ring`

## Requirements
- R1: While mreset is high at a rising clock edge, all q bits become 0 and the capture counter restarts from 0.
- R2: mreset takes priority over test_en and over d: with test_en=1 and d all ones, q is still 0 after the edge.
- R3: With test_en=0 and mreset=0, q takes the value of d at each rising edge (bit i from d[i]).
- R4: With test_en=1 and done=0, each edge loads q[i] = d[i] XOR q[i-1] for i>0, and q[0] = d[0] XOR q[N-1].
- R5: With test_en=1 and d held at 0, the ring rotates one position towards higher indices on each edge and returns to its starting value after N edges (polynomial x^n+1).
- R6: After run_len capture edges in one test session, done reads 1. While done is 1, q holds its value (the signature) whatever d is.
- R7: With run_len=0, done reads 1 as soon as test_en is 1 and the counter is 0, and no capture takes place.
- R8: An edge with test_en=0 clears the capture counter, so the next test session again takes run_len capture edges before done. done is 0 whenever test_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| mreset | input | 1 | Synchronous master reset, active high, highest priority |
| test_en | input | 1 | 1 selects the self-test ring, 0 selects plain D flip-flops |
| run_len | input | CW | Number of capture clocks in one test session |
| d | input | N | Functional data inputs, one per cell |
| q | output | N | Cell outputs |
| done | output | 1 | Test session complete; q holds the signature |

## Verification
A short vector table alternates normal loads and ring captures with sparse, dense and complementary data words. This separates a plain load from an XOR capture and catches a wrong rotation direction or a missing wrap from cell N-1 to cell 0. A single set bit with zero data shows the pure x^n+1 rotation and its period of N. A closed loop through a small nonlinear function checks the full signature and the exact edge on which done rises against an independent model. Zero-length runs, leaving and re-entering test mode, and reset during test mode each check counter and priority behaviour that the other patterns cannot reach.

// File: rtl/cstp_ring.sv
`timescale 1ns/1ps
module cstp_ring #(
  parameter int N  = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          mreset,
  input  logic          test_en,
  input  logic [CW-1:0] run_len,
  input  logic [N-1:0]  d,
  output logic [N-1:0]  q,
  output logic          done
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [N-1:0]  ring_prev;
  logic [CW-1:0] cnt;
  logic          capture;

  assign ring_prev = {q[N-2:0], q[N-1]};
  assign done      = test_en && (cnt == run_len);
  assign capture   = test_en && !done;

  always_ff @(posedge clk) begin
    if (mreset) begin
      q   <= '0;
      cnt <= '0;
    end else if (!test_en) begin
      q   <= d;
      cnt <= '0;
    end else if (capture) begin
      q   <= d ^ ring_prev;
      cnt <= cnt + ONE;
    end
  end

  AST_MRESET_CLEARS: assert property (@(posedge clk)
    mreset |=> (q == '0)); // R1
  AST_NORMAL_LOAD: assert property (@(posedge clk) disable iff (mreset)
    !test_en |=> (q == $past(d))); // R3
  AST_RING_CAPTURE: assert property (@(posedge clk) disable iff (mreset)
    (test_en && !done) |=> (q == ($past(d) ^ {$past(q[N-2:0]), $past(q[N-1])}))); // R4
  AST_SIGNATURE_HOLD: assert property (@(posedge clk) disable iff (mreset)
    (test_en && done) |=> $stable(q)); // R6
  AST_DONE_NEEDS_TEST: assert property (@(posedge clk) disable iff (mreset)
    !test_en |-> !done); // R8
endmodule

// File: tb/test_cstp_ring.sv
`timescale 1ns/1ps
module test_cstp_ring;
  localparam int N  = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          mreset, test_en, loop_on;
  logic [CW-1:0] run_len;
  logic [N-1:0]  d, d_drv, q, mdl;
  logic          done;
  int            errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  function automatic logic [N-1:0] rot(input logic [N-1:0] x);
    return {x[N-2:0], x[N-1]};
  endfunction

  function automatic logic [N-1:0] cut_f(input logic [N-1:0] x);
    return (x + 8'h3B) ^ {x[3:0], x[7:4]};
  endfunction

  assign d = loop_on ? cut_f(q) : d_drv;

  cstp_ring #(.N(N), .CW(CW)) i_cstp_ring (
    .clk(clk), .mreset(mreset), .test_en(test_en), .run_len(run_len),
    .d(d), .q(q), .done(done)
  );

  // {test_en, d, expected q}, applied in order from the all-zero state
  localparam logic [2*N:0] TAB [8] = '{
    {1'b0, 8'hA5, 8'hA5}, {1'b1, 8'h00, 8'h4B},
    {1'b1, 8'h0F, 8'h99}, {1'b1, 8'hF0, 8'hC3},
    {1'b0, 8'h3C, 8'h3C}, {1'b1, 8'h81, 8'hF9},
    {1'b1, 8'hFF, 8'h0C}, {1'b1, 8'h00, 8'h18}
  };

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    mreset = 1'b1; test_en = 1'b0; loop_on = 1'b0; d_drv = 8'h77; run_len = 16'hFFFF;
    tick();
    chk("R1 reset q", q, 8'h00);
    chk("R1 reset done", {7'd0, done}, 8'h00);

    @(negedge clk); mreset = 1'b0;
    foreach (TAB[i]) begin
      @(negedge clk);
      test_en = TAB[i][2*N];
      d_drv   = TAB[i][2*N-1:N];
      tick();
      chk(TAB[i][2*N] ? "R4 table capture" : "R3 table load", q, TAB[i][N-1:0]);
    end

    @(negedge clk); mreset = 1'b1; test_en = 1'b1; d_drv = 8'hFF;
    tick();
    chk("R2 reset over test", q, 8'h00);

    @(negedge clk); mreset = 1'b0; test_en = 1'b0; d_drv = 8'h01;
    tick();
    @(negedge clk); test_en = 1'b1; d_drv = 8'h00;
    tick();
    chk("R5 one step", q, 8'h02);
    repeat (N-1) tick();
    chk("R5 full period", q, 8'h01);

    @(negedge clk); mreset = 1'b1; test_en = 1'b0;
    tick();
    @(negedge clk); mreset = 1'b0; run_len = 16'd40; loop_on = 1'b1; test_en = 1'b1;
    mdl = 8'h00;
    for (int k = 1; k <= 40; k++) begin
      mdl = cut_f(mdl) ^ rot(mdl);
      tick();
      if (k == 39) chk("R6 done early", {7'd0, done}, 8'h00);
    end
    chk("R6 done on time", {7'd0, done}, 8'h01);
    chk("R6 signature", q, mdl);
    repeat (3) tick();
    chk("R6 signature held", q, mdl);
    chk("R6 done held", {7'd0, done}, 8'h01);

    @(negedge clk); loop_on = 1'b0; test_en = 1'b0; d_drv = 8'h5A;
    tick();
    chk("R8 done low in normal", {7'd0, done}, 8'h00);
    @(negedge clk); run_len = 16'd0; test_en = 1'b1; d_drv = 8'hFF;
    #1;
    chk("R7 zero run done", {7'd0, done}, 8'h01);
    tick();
    chk("R7 zero run no capture", q, 8'h5A);

    @(negedge clk); test_en = 1'b0; d_drv = 8'h81;
    tick();
    @(negedge clk); test_en = 1'b1; run_len = 16'd2; d_drv = 8'h00;
    tick();
    chk("R8 restart first", q, 8'h03);
    chk("R8 not done yet", {7'd0, done}, 8'h00);
    tick();
    chk("R8 restart second", q, 8'h06);
    chk("R8 done after restart", {7'd0, done}, 8'h01);
    tick();
    chk("R8 frozen", q, 8'h06);

    finish_run();
  end
endmodule